// File: doc/BRIEF.md
# Fundamental Positive-Sequence Extractor

This block takes sampled three-phase currents and splits them into two parts. One part is the fundamental positive-sequence vector. The other is everything else: harmonics plus unbalance. That second part is the current an active-filter controller has to inject, so it serves as the compensation reference. Each strobed sample is first mapped onto a complex stationary-frame vector (alpha, beta). The vector then passes through a chain of delay-and-rotate cancellation stages.

Each stage averages the present vector with a copy of itself from `SPP/n` samples earlier, rotated forward by `2*pi/n`. The stage orders are n = 4, 8, 16 and so on. For the +1 sequence the rotation exactly undoes the delay, so that component passes with unity gain and zero phase shift. Orders whose shift lands on the opposite side of the circle are cancelled. Fractional delays are formed by linear interpolation between two adjacent history entries in a circular buffer owned by the stage. The residual is the input vector minus the extracted fundamental, taken for the same sample.

A caller pulses `smp_i` once per sample period with the three phase currents present. The outputs for that sample appear a fixed number of clocks later and hold until the next sample replaces them.

Top module: `cdsc_fund_extract`

## Requirements
- R1: For every valid sample, `fund + res` equals the Clarke vector of that sample's inputs within 2 LSB on each axis. The Clarke vector is alpha = (2a - b - c)/3 and beta = (b - c)/sqrt(3), computed in the input's LSB scale.
- R2: A pure +1 sequence input of amplitude A appears on the fundamental outputs with unity gain and no phase shift, within 40 LSB for A = 6000. The residual stays within 40 LSB of zero.
- R3: A pure negative-sequence fundamental (order -1) is removed from the fundamental outputs, which stay within 40 LSB of zero.
- R4: Odd orders -5, +7, -3, +5 and +9 are removed from the fundamental outputs. They appear in the residual, while a +1 component present at the same time is still passed. The tolerance is 100 LSB.
- R5: After an amplitude step in the input, the fundamental outputs reach the new value within 45 samples (9 ms at 5 kHz and 50 Hz).
- R6: With default parameters, `vld_o` stays low for the first 46 samples after reset and rises with the 47th. The count is the sum over stages of (integer part of SPP/n) + 1. Once high, `vld_o` stays high until reset.
- R7: Reset drives all four vector outputs to 0 and `vld_o` low. While `vld_o` is low, the vector outputs read 0.
- R8: Outputs for a sample change on the (NSTG+2)-th rising clock edge counting the edge that samples the strobe, and otherwise hold. Strobes must be at least NSTG+1 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 1 | One-clock sample strobe |
| ia_i | input | DW | Phase a current, signed |
| ib_i | input | DW | Phase b current, signed |
| ic_i | input | DW | Phase c current, signed |
| fund_a_o | output | DW+2 | Fundamental vector, alpha axis |
| fund_b_o | output | DW+2 | Fundamental vector, beta axis |
| res_a_o | output | DW+2 | Residual (compensation reference), alpha axis |
| res_b_o | output | DW+2 | Residual (compensation reference), beta axis |
| vld_o | output | 1 | Outputs hold a settled result |

## Verification
The bench builds the block with its defaults: 16-bit samples, 100 samples per fundamental period, three stages, two bits of delay fraction and 14-bit coefficients. With these values the first stage has an integer delay of 25 samples. The second and third stages have fractional delays of 12.5 and 6.25 samples. The harmonic and settling tests therefore reach the interpolation path at both half and quarter weights. They also reach the exact cancellation of orders that the integer stage removes on its own.

// File: rtl/cdsc_pkg.sv
package cdsc_pkg;

   // integer square root, digit by digit
   function automatic longint isqrt(input longint val);
      longint v, r, b;
      v = val;
      r = 0;
      b = longint'(1) <<< 60;
      while (b > v) b = b >>> 2;
      while (b != 0) begin
         if (v >= r + b) begin
            v = v - r - b;
            r = (r >>> 1) + b;
         end else begin
            r = r >>> 1;
         end
         b = b >>> 2;
      end
      return r;
   endfunction

   // round(2^f / 3)
   function automatic int k_third(input int f);
      return ((1 << f) + 1) / 3;
   endfunction

   // round(2^f / sqrt(3))
   function automatic int k_isqrt3(input int f);
      longint t;
      t = isqrt((longint'(4) <<< (2 * f)) / 3);
      return int'((t + 1) >>> 1);
   endfunction

   // cos or sin of 2*pi/n scaled by 2^f, n a power of two >= 4, by half-angle steps
   function automatic int rot_coef(input int n, input int f, input bit want_sin);
      longint sc, c, s, c2;
      int m;
      sc = longint'(1) <<< f;
      c = 0;
      s = sc;
      m = 4;
      while (m < n) begin
         c2 = isqrt(((sc + c) * sc) >>> 1);
         s = (s * sc + c2) / (2 * c2);
         c = c2;
         m = m * 2;
      end
      return want_sin ? int'(s) : int'(c);
   endfunction

   // samples before the last stage holds a full history
   function automatic int fill_total(input int spp, input int qb, input int nstg);
      int t;
      t = 0;
      for (int j = 0; j < nstg; j++) t += (((spp << qb) / (4 << j)) >> qb) + 1;
      return t;
   endfunction

endpackage

// File: rtl/cdsc_clarke.sv
module cdsc_clarke #(
   parameter int DW = 16,
   parameter int IW = 18,
   parameter int CF = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld,
   input  logic signed [DW-1:0] ph_a,
   input  logic signed [DW-1:0] ph_b,
   input  logic signed [DW-1:0] ph_c,
   output logic signed [IW-1:0] al_o,
   output logic signed [IW-1:0] be_o,
   output logic                 vld_o
);
   localparam int SW = DW + 2;
   localparam int KW = CF + 2;
   localparam int PW = SW + KW;
   localparam logic signed [KW-1:0] K_A = KW'(cdsc_pkg::k_third(CF));
   localparam logic signed [KW-1:0] K_B = KW'(cdsc_pkg::k_isqrt3(CF));

   if (IW < DW + 1) begin : g_bad_iw
      $error("cdsc_clarke: IW must be at least DW+1");
   end

   logic signed [SW-1:0] sum2, dif;
   logic signed [PW-1:0] pa, pb;

   always_comb begin
      sum2 = (SW'(ph_a) <<< 1) - SW'(ph_b) - SW'(ph_c);
      dif  = SW'(ph_b) - SW'(ph_c);
      pa   = PW'(sum2) * PW'(K_A) + (PW'(1) <<< (CF - 1));
      pb   = PW'(dif) * PW'(K_B) + (PW'(1) <<< (CF - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_o  <= '0;
         be_o  <= '0;
         vld_o <= 1'b0;
      end else if (ld) begin
         al_o  <= IW'(pa >>> CF);
         be_o  <= IW'(pb >>> CF);
         vld_o <= 1'b1;
      end
   end
endmodule

// File: rtl/cdsc_dsc_stage.sv
module cdsc_dsc_stage #(
   parameter int IW  = 18,
   parameter int CF  = 14,
   parameter int QB  = 2,
   parameter int SPP = 100,
   parameter int N   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld,
   input  logic                 in_vld,
   input  logic signed [IW-1:0] in_re,
   input  logic signed [IW-1:0] in_im,
   output logic signed [IW-1:0] out_re,
   output logic signed [IW-1:0] out_im,
   output logic                 out_vld
);
   localparam int DQ = (SPP << QB) / N;        // delay in 2^-QB sample units
   localparam int DI = DQ >> QB;               // whole samples
   localparam int DF = DQ - (DI << QB);        // fraction
   localparam int L  = DI + 1;                 // history depth
   localparam int AW = (L > 1) ? $clog2(L) : 1;
   localparam int CW = CF + 2;
   localparam int HW = IW + QB + 2;
   localparam int PW = HW + CW + 2;
   localparam int SH = CF + QB + 1;            // coefficient, fraction and the halving
   localparam logic signed [CW-1:0] C_ROT = CW'(cdsc_pkg::rot_coef(N, CF, 1'b0));
   localparam logic signed [CW-1:0] S_ROT = CW'(cdsc_pkg::rot_coef(N, CF, 1'b1));
   localparam logic signed [HW-1:0] W_NEW = HW'((1 << QB) - DF);
   localparam logic signed [HW-1:0] W_OLD = HW'(DF);
   localparam logic [AW:0]          FULL  = (AW + 1)'(L);

   if (N < 4 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("cdsc_dsc_stage: N must be a power of two, at least 4");
   end
   if (((SPP << QB) % N) != 0) begin : g_bad_div
      $error("cdsc_dsc_stage: SPP*2^QB must be a multiple of N");
   end

   logic signed [IW-1:0] mem_re [L];
   logic signed [IW-1:0] mem_im [L];
   logic [AW-1:0] wp;
   logic [AW:0]   cnt;
   logic signed [IW-1:0] h0_re, h0_im, h1_re, h1_im;

   if (L == 1) begin : g_short
      // whole delay is zero: newer tap is the present sample
      always_comb begin
         h0_re = in_re;
         h0_im = in_im;
         h1_re = mem_re[0];
         h1_im = mem_im[0];
      end
   end else begin : g_long
      logic [AW-1:0] rp;
      always_comb begin
         rp    = (wp == AW'(L - 1)) ? '0 : wp + 1'b1;
         h0_re = mem_re[rp];
         h0_im = mem_im[rp];
         h1_re = mem_re[wp];
         h1_im = mem_im[wp];
      end
   end

   logic signed [HW-1:0] d_re, d_im;
   logic signed [PW-1:0] acc_re, acc_im;

   always_comb begin
      d_re   = HW'(h0_re) * W_NEW + HW'(h1_re) * W_OLD;
      d_im   = HW'(h0_im) * W_NEW + HW'(h1_im) * W_OLD;
      acc_re = (PW'(in_re) <<< (CF + QB)) + PW'(C_ROT) * PW'(d_re)
               - PW'(S_ROT) * PW'(d_im) + (PW'(1) <<< (SH - 1));
      acc_im = (PW'(in_im) <<< (CF + QB)) + PW'(S_ROT) * PW'(d_re)
               + PW'(C_ROT) * PW'(d_im) + (PW'(1) <<< (SH - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp      <= '0;
         cnt     <= '0;
         out_re  <= '0;
         out_im  <= '0;
         out_vld <= 1'b0;
      end else if (ld) begin
         out_re  <= IW'(acc_re >>> SH);
         out_im  <= IW'(acc_im >>> SH);
         out_vld <= in_vld && (cnt == FULL);
         if (in_vld) begin
            wp <= (wp == AW'(L - 1)) ? '0 : wp + 1'b1;
            if (cnt != FULL) cnt <= cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (ld && in_vld) begin
         mem_re[wp] <= in_re;
         mem_im[wp] <= in_im;
      end
   end
endmodule

// File: rtl/cdsc_combine.sv
module cdsc_combine #(
   parameter int IW = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld,
   input  logic signed [IW-1:0] al,
   input  logic signed [IW-1:0] be,
   input  logic signed [IW-1:0] f_re,
   input  logic signed [IW-1:0] f_im,
   input  logic                 f_vld,
   output logic signed [IW-1:0] fund_a,
   output logic signed [IW-1:0] fund_b,
   output logic signed [IW-1:0] res_a,
   output logic signed [IW-1:0] res_b,
   output logic                 vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fund_a <= '0;
         fund_b <= '0;
         res_a  <= '0;
         res_b  <= '0;
         vld    <= 1'b0;
      end else if (ld) begin
         if (f_vld) begin
            fund_a <= f_re;
            fund_b <= f_im;
            res_a  <= al - f_re;
            res_b  <= be - f_im;
            vld    <= 1'b1;
         end else begin
            fund_a <= '0;
            fund_b <= '0;
            res_a  <= '0;
            res_b  <= '0;
            vld    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cdsc_fund_extract.sv
module cdsc_fund_extract #(
   parameter int DW   = 16,
   parameter int SPP  = 100,
   parameter int NSTG = 3,
   parameter int QB   = 2,
   parameter int CF   = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_i,
   input  logic signed [DW-1:0] ia_i,
   input  logic signed [DW-1:0] ib_i,
   input  logic signed [DW-1:0] ic_i,
   output logic signed [DW+1:0] fund_a_o,
   output logic signed [DW+1:0] fund_b_o,
   output logic signed [DW+1:0] res_a_o,
   output logic signed [DW+1:0] res_b_o,
   output logic                 vld_o
);
   localparam int IW = DW + 2;

   if (NSTG < 1 || NSTG > 5) begin : g_bad_nstg
      $error("cdsc_fund_extract: NSTG must be 1..5");
   end
   if (DW < 8 || DW > 28) begin : g_bad_dw
      $error("cdsc_fund_extract: DW must be 8..28");
   end
   if (CF < 8 || CF > 20) begin : g_bad_cf
      $error("cdsc_fund_extract: CF must be 8..20");
   end
   if (((SPP << QB) % (4 << (NSTG - 1))) != 0) begin : g_bad_spp
      $error("cdsc_fund_extract: SPP*2^QB must divide by the deepest stage order");
   end

   // load strobes for each pipeline step of one sample
   logic [NSTG:0] ldp;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ldp <= '0;
      else        ldp <= {ldp[NSTG-1:0], smp_i};
   end

   logic signed [IW-1:0] al, be;
   logic                 cl_vld;

   cdsc_clarke #(.DW(DW), .IW(IW), .CF(CF)) u_clarke (
      .clk(clk), .rst_n(rst_n), .ld(smp_i),
      .ph_a(ia_i), .ph_b(ib_i), .ph_c(ic_i),
      .al_o(al), .be_o(be), .vld_o(cl_vld)
   );

   logic signed [IW-1:0] st_re [NSTG];
   logic signed [IW-1:0] st_im [NSTG];
   logic [NSTG-1:0]      st_vld;

   for (genvar j = 0; j < NSTG; j++) begin : g_stg
      logic signed [IW-1:0] x_re, x_im;
      logic                 x_vld;
      if (j == 0) begin : g_head
         assign x_re  = al;
         assign x_im  = be;
         assign x_vld = cl_vld;
      end else begin : g_link
         assign x_re  = st_re[j-1];
         assign x_im  = st_im[j-1];
         assign x_vld = st_vld[j-1];
      end
      cdsc_dsc_stage #(.IW(IW), .CF(CF), .QB(QB), .SPP(SPP), .N(4 << j)) u_stg (
         .clk(clk), .rst_n(rst_n), .ld(ldp[j]), .in_vld(x_vld),
         .in_re(x_re), .in_im(x_im),
         .out_re(st_re[j]), .out_im(st_im[j]), .out_vld(st_vld[j])
      );
   end

   cdsc_combine #(.IW(IW)) u_comb (
      .clk(clk), .rst_n(rst_n), .ld(ldp[NSTG]),
      .al(al), .be(be),
      .f_re(st_re[NSTG-1]), .f_im(st_im[NSTG-1]), .f_vld(st_vld[NSTG-1]),
      .fund_a(fund_a_o), .fund_b(fund_b_o),
      .res_a(res_a_o), .res_b(res_b_o), .vld(vld_o)
   );
endmodule

// File: rtl/cdsc_fund_extract_chk.sv
module cdsc_fund_extract_chk #(
   parameter int DW   = 16,
   parameter int SPP  = 100,
   parameter int NSTG = 3,
   parameter int QB   = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_i,
   input logic signed [DW+1:0] fund_a_o,
   input logic signed [DW+1:0] fund_b_o,
   input logic signed [DW+1:0] res_a_o,
   input logic signed [DW+1:0] res_b_o,
   input logic                 vld_o
);
   localparam int FILL  = cdsc_pkg::fill_total(SPP, QB, NSTG);
   localparam int CNT_W = $clog2(FILL + 2) + 1;

   logic [NSTG:0]    hist;
   logic [CNT_W-1:0] scnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         scnt <= '0;
      end else begin
         hist <= {hist[NSTG-1:0], smp_i};
         if (smp_i && scnt <= CNT_W'(FILL)) scnt <= scnt + 1'b1;
      end
   end

   // R6: no valid result before the histories are full
   assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (scnt > CNT_W'(FILL)));

   // R6: valid never drops without reset
   assert_valid_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> vld_o);

   // R7: vector outputs are zero while not valid
   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> (fund_a_o == '0 && fund_b_o == '0 && res_a_o == '0 && res_b_o == '0));

   // R8: outputs move only on the final pipeline edge of a sample
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hist[NSTG] |=> ($stable(fund_a_o) && $stable(fund_b_o) &&
                       $stable(res_a_o) && $stable(res_b_o) && $stable(vld_o)));

   // R8: strobe spacing respected
   assert_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      smp_i |-> (hist[NSTG-1:0] == '0));
endmodule

bind cdsc_fund_extract cdsc_fund_extract_chk #(
   .DW(DW), .SPP(SPP), .NSTG(NSTG), .QB(QB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_i(smp_i),
   .fund_a_o(fund_a_o), .fund_b_o(fund_b_o),
   .res_a_o(res_a_o), .res_b_o(res_b_o), .vld_o(vld_o)
);

// File: tb/sim_cdsc_fund_extract.sv
module sim_cdsc_fund_extract;
   localparam int  DW   = 16;
   localparam int  OW   = DW + 2;
   localparam int  SPP  = 100;
   localparam int  FILL = 46;   // R6: 26 + 13 + 7
   localparam real PI   = 3.14159265358979;
   localparam int  NC   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp = 1'b0;
   logic signed [DW-1:0] ia = '0, ib = '0, ic = '0;
   logic signed [OW-1:0] fa, fb, ra, rb;
   logic vld;

   int errors = 0, checks = 0, k_smp = 0, lat_bad = 0;
   int  comp_h [NC];
   real comp_a [NC];
   real in_al, in_be, ex_fa, ex_fb;
   logic signed [OW-1:0] p_fa, p_fb, p_ra, p_rb;

   always #5 clk = ~clk;

   cdsc_fund_extract u0 (
      .clk(clk), .rst_n(rst_n), .smp_i(smp),
      .ia_i(ia), .ib_i(ib), .ic_i(ic),
      .fund_a_o(fa), .fund_b_o(fb), .res_a_o(ra), .res_b_o(rb), .vld_o(vld)
   );

   task automatic chk_near(input string req, input int act, input real expv, input real tol);
      checks++;
      if ((act - expv) > tol || (expv - act) > tol) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0.1f (tol %0.1f)", req, act, expv, tol);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic set_comps(input int h0, input real a0, input int h1, input real a1,
                            input int h2, input real a2, input int h3, input real a3,
                            input int h4, input real a4);
      comp_h[0] = h0; comp_a[0] = a0; comp_h[1] = h1; comp_a[1] = a1;
      comp_h[2] = h2; comp_a[2] = a2; comp_h[3] = h3; comp_a[3] = a3;
      comp_h[4] = h4; comp_a[4] = a4;
   endtask

   // one sample: drive, strobe, snapshot before and after the output edge
   task automatic apply_sample();
      real phi, al, be;
      int a, b, c;
      phi = 2.0 * PI * k_smp / SPP;
      al = 0.0; be = 0.0; ex_fa = 0.0; ex_fb = 0.0;
      for (int i = 0; i < NC; i++) begin
         al += comp_a[i] * $cos(comp_h[i] * phi);
         be += comp_a[i] * $sin(comp_h[i] * phi);
         if (comp_h[i] == 1) begin
            ex_fa += comp_a[i] * $cos(phi);
            ex_fb += comp_a[i] * $sin(phi);
         end
      end
      a = int'(al);
      b = int'(-al / 2.0 + $sqrt(3.0) / 2.0 * be);
      c = int'(-al / 2.0 - $sqrt(3.0) / 2.0 * be);
      in_al = (2.0 * a - b - c) / 3.0;
      in_be = (b - c) / $sqrt(3.0);
      k_smp++;
      @(negedge clk);
      ia = DW'(a); ib = DW'(b); ic = DW'(c); smp = 1'b1;
      @(negedge clk);
      smp = 1'b0;
      repeat (3) @(negedge clk);
      // R8: one edge before the output edge nothing has moved yet
      if (fa != p_fa || fb != p_fb || ra != p_ra || rb != p_rb) lat_bad++;
      @(negedge clk);
      p_fa = fa; p_fb = fb; p_ra = ra; p_rb = rb;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_eq("R7 reset vld", int'(vld), 0);
      chk_eq("R7 reset fund_a", int'(fa), 0);
      chk_eq("R7 reset res_b", int'(rb), 0);
      p_fa = fa; p_fb = fb; p_ra = ra; p_rb = rb;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_fill();
      int early;
      early = 0;
      set_comps(1, 6000.0, 0, 0.0, 0, 0.0, 0, 0.0, 0, 0.0);
      for (int i = 0; i < FILL; i++) begin
         apply_sample();
         if (vld) early++;
         if (!vld && (fa != 0 || ra != 0)) early++;
      end
      chk_eq("R6 valid low during fill", early, 0);
      apply_sample();
      chk_eq("R6 valid on sample 47", int'(vld), 1);
   endtask

   task automatic t_pass();
      for (int i = 0; i < 100; i++) begin
         apply_sample();
         if (i % 10 == 0) begin
            chk_near("R2 fund_a", int'(fa), ex_fa, 40.0);
            chk_near("R2 fund_b", int'(fb), ex_fb, 40.0);
            chk_near("R2 res_a", int'(ra), 0.0, 40.0);
            chk_near("R1 sum_a", int'(fa) + int'(ra), in_al, 2.0);
            chk_near("R1 sum_b", int'(fb) + int'(rb), in_be, 2.0);
            chk_eq("R6 valid stays", int'(vld), 1);
         end
      end
   endtask

   task automatic t_neg();
      set_comps(-1, 5000.0, 0, 0.0, 0, 0.0, 0, 0.0, 0, 0.0);
      for (int i = 0; i < 50; i++) apply_sample();
      for (int i = 0; i < 30; i++) begin
         apply_sample();
         if (i % 6 == 0) begin
            chk_near("R3 fund_a", int'(fa), 0.0, 40.0);
            chk_near("R3 fund_b", int'(fb), 0.0, 40.0);
            chk_near("R3 res_a", int'(ra), in_al, 42.0);
         end
      end
   endtask

   task automatic t_harm();
      set_comps(1, 6000.0, -5, 1500.0, 7, 1000.0, -3, 800.0, 9, 600.0);
      for (int i = 0; i < 50; i++) apply_sample();
      for (int i = 0; i < 40; i++) begin
         apply_sample();
         if (i % 8 == 0) begin
            chk_near("R4 fund_a", int'(fa), ex_fa, 100.0);
            chk_near("R4 fund_b", int'(fb), ex_fb, 100.0);
            chk_near("R4 res_a", int'(ra), in_al - ex_fa, 100.0);
            chk_near("R1 sum_b", int'(fb) + int'(rb), in_be, 2.0);
         end
      end
      set_comps(5, 1200.0, 0, 0.0, 0, 0.0, 0, 0.0, 0, 0.0);
      for (int i = 0; i < 50; i++) apply_sample();
      for (int i = 0; i < 20; i++) begin
         apply_sample();
         if (i % 5 == 0) chk_near("R4 plus5 fund_a", int'(fa), 0.0, 100.0);
      end
   endtask

   task automatic t_step();
      set_comps(1, 6000.0, 0, 0.0, 0, 0.0, 0, 0.0, 0, 0.0);
      for (int i = 0; i < 60; i++) apply_sample();
      comp_a[0] = 3000.0;
      for (int i = 0; i < 45; i++) apply_sample();
      for (int i = 0; i < 10; i++) begin
         apply_sample();
         if (i % 3 == 0) begin
            chk_near("R5 settled fund_a", int'(fa), ex_fa, 40.0);
            chk_near("R5 settled fund_b", int'(fb), ex_fb, 40.0);
         end
      end
   endtask

   task automatic t_latency();
      chk_eq("R8 outputs held until the output edge", lat_bad, 0);
   endtask

   task automatic t_midreset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk_eq("R7 midrun vld", int'(vld), 0);
      chk_eq("R7 midrun fund_b", int'(fb), 0);
      chk_eq("R7 midrun res_a", int'(ra), 0);
      p_fa = fa; p_fb = fb; p_ra = ra; p_rb = rb;
      rst_n = 1'b1;
      @(negedge clk);
      apply_sample();
      chk_eq("R6 refill after reset", int'(vld), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_fill();
      t_pass();
      t_neg();
      t_harm();
      t_step();
      t_latency();
      t_midreset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule